// File: doc/BRIEF.md
# Display Bitmap Memory Host Port

This block sits between a host bus decoder and the bitmap memory of a dot-matrix display controller. The memory holds 132 columns by 65 lines. The lines are grouped into nine byte-wide pages. Pages 0 to 7 are full bytes. Page 8 carries a single indicator line, stored in data bit 0. The host selects a page and a column through address commands. The column pointer then advances by itself on every data access.

All host data passes through a one-byte holding register. A write lands in the array on the clock edge that accepts it, and the holder keeps a copy. A read presents the current holder contents and then refills the holder from the addressed location. As a result, the first read after an address change or a write returns stale data. The wanted byte arrives on the following read.

The address registers are visible directly as a status path, with no pipeline. A separate registered read port serves the display scan side. A segment-direction flag mirrors the column order of that port.

Top module: `dram_host_port`

## Requirements
- R1: After reset, the page register and the column register read 0, `rd_data` is 0x00 and `seg_rev` is 0.
- R2: `set_page` loads `addr_val` into the page register only when the value is 0 to 8, and `set_col` loads the column register only when the value is 0 to 131. Out-of-range values leave the register unchanged. Setting one register never alters the other.
- R3: Every accepted data write or read advances the column register by one on the accepting edge.
- R4: At column 131 an accepted access leaves the column at 131, and the page register never changes as a result of an access.
- R5: An accepted write stores its byte at the current page and column on the accepting edge, and the holder takes that byte.
- R6: During a read cycle, `rd_data` shows the holder. On the accepting edge the holder is reloaded from the address in effect before the column step. A read directly after an address set or a write therefore returns the previous holder value.
- R7: In page 8 only bit 0 is stored. Bits 7 to 1 of a byte written there are dropped, and such a byte is read back as 0.
- R8: `cur_page` and `cur_col` reflect the registers in the cycle right after the edge that changed them, with no dummy cycle.
- R9: With `seg_rev`=0, scan segment s reads column s. With `seg_rev`=1, it reads column 131-s. `scan_data` is valid one edge after `scan_page`/`scan_seg` are applied. A page above 8 or a segment above 131 yields 0x00. `set_dir` loads `dir_val` into `seg_rev`.
- R10: When `set_page` or `set_col` is high, `wr_en` and `rd_en` are ignored. When `wr_en` and `rd_en` are both high, only the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_page | input | 1 | Load page register from addr_val |
| set_col | input | 1 | Load column register from addr_val |
| set_dir | input | 1 | Load segment-direction flag from dir_val |
| addr_val | input | 8 | Address value for set_page / set_col |
| dir_val | input | 1 | Segment-direction value |
| wr_en | input | 1 | Host data write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host data read strobe |
| rd_data | output | 8 | Holder contents returned to host |
| cur_page | output | 4 | Page register (status) |
| cur_col | output | 8 | Column register (status) |
| seg_rev | output | 1 | Segment-direction flag |
| scan_page | input | 4 | Scan-side page select |
| scan_seg | input | 8 | Scan-side segment index |
| scan_data | output | 8 | Scan-side byte, one cycle latency |

## Verification
The checker watches every cycle for the following: both address registers stay in range, the column steps and saturates on each accepted access, and the page stays put during accesses. It also checks that the holder mirrors a written byte, that bits 7 to 1 of page 8 stay clear, and that an idle cycle changes nothing. Several properties can only be shown by the bench's scenarios, because they depend on array contents across many cycles. These are the one-read lag of the dummy-read pipeline, the commit of a write seen by a later read, the rejection of out-of-range address values, the priority rules, and the mirrored column order on the scan port.

// File: rtl/dram_pkg.sv
package dram_pkg;
    localparam int PAGES   = 9;
    localparam int COLS    = 132;
    localparam int DW      = 8;
    localparam int PW      = 4;
    localparam int CW      = 8;
    localparam int DEPTH   = PAGES * COLS;
    localparam int AW      = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] page;
        logic [CW-1:0] col;
    } host_addr_t;
endpackage

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl #(
    parameter int PAGES = dram_pkg::PAGES,
    parameter int COLS  = dram_pkg::COLS,
    parameter int PW    = dram_pkg::PW,
    parameter int CW    = dram_pkg::CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_page,
    input  logic          set_col,
    input  logic [CW-1:0] addr_val,
    input  logic          step,
    output logic [PW-1:0] page_q,
    output logic [CW-1:0] col_q
);
    localparam logic [CW-1:0] LAST_COL  = CW'(COLS - 1);
    localparam logic [CW-1:0] PAGE_LIM  = CW'(PAGES);
    localparam logic [CW-1:0] COL_LIM   = CW'(COLS);

    dram_pkg::host_addr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_page && (addr_val < PAGE_LIM))
            st_d.page = addr_val[PW-1:0];
        if (set_col && (addr_val < COL_LIM))
            st_d.col = addr_val;
        if (step && (st_q.col != LAST_COL))
            st_d.col = st_q.col + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page_q = st_q.page;
    assign col_q  = st_q.col;
endmodule

// File: rtl/dram_array.sv
module dram_array #(
    parameter int DW    = dram_pkg::DW,
    parameter int DEPTH = dram_pkg::DEPTH,
    parameter int AW    = dram_pkg::AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[host_addr] <= wdata;
        scan_rdata <= cells[scan_addr];
    end

    assign host_rdata = cells[host_addr];
endmodule

// File: rtl/dram_scan_map.sv
module dram_scan_map #(
    parameter int PAGES = dram_pkg::PAGES,
    parameter int COLS  = dram_pkg::COLS,
    parameter int PW    = dram_pkg::PW,
    parameter int CW    = dram_pkg::CW,
    parameter int AW    = dram_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_dir,
    input  logic          dir_val,
    input  logic [PW-1:0] scan_page,
    input  logic [CW-1:0] scan_seg,
    output logic          seg_rev,
    output logic [AW-1:0] scan_addr,
    output logic          scan_ok
);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    typedef struct packed { logic rev; } dir_st_t;
    dir_st_t st_d, st_q;
    logic [CW-1:0] col;

    always_comb begin
        st_d = st_q;
        if (set_dir) st_d.rev = dir_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_rev   = st_q.rev;
    assign col       = st_q.rev ? (LAST_COL - scan_seg) : scan_seg;
    assign scan_ok   = (scan_page < PW'(PAGES)) && (scan_seg < CW'(COLS));
    assign scan_addr = AW'(scan_page) * AW'(COLS) + AW'(col);
endmodule

// File: rtl/dram_host_port.sv
module dram_host_port #(
    parameter int PAGES = dram_pkg::PAGES,
    parameter int COLS  = dram_pkg::COLS,
    parameter int DW    = dram_pkg::DW,
    parameter int PW    = dram_pkg::PW,
    parameter int CW    = dram_pkg::CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_page,
    input  logic          set_col,
    input  logic          set_dir,
    input  logic [CW-1:0] addr_val,
    input  logic          dir_val,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] cur_page,
    output logic [CW-1:0] cur_col,
    output logic          seg_rev,
    input  logic [PW-1:0] scan_page,
    input  logic [CW-1:0] scan_seg,
    output logic [DW-1:0] scan_data
);
    localparam int DEPTH = PAGES * COLS;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [PW-1:0] IND_PAGE = PW'(PAGES - 1);

    typedef struct packed {
        logic [DW-1:0] holder;
        logic          scan_ok;
    } port_st_t;

    port_st_t st_d, st_q;

    logic          addr_cmd, wr_go, rd_go;
    logic [DW-1:0] keep_mask, wbyte, host_rdata, scan_raw;
    logic [AW-1:0] host_addr, scan_addr;
    logic          scan_ok;

    assign addr_cmd  = set_page | set_col;
    assign wr_go     = wr_en & ~addr_cmd;
    assign rd_go     = rd_en & ~addr_cmd & ~wr_en;
    assign keep_mask = (cur_page == IND_PAGE) ? DW'(1) : '1;
    assign wbyte     = wr_data & keep_mask;
    assign host_addr = AW'(cur_page) * AW'(COLS) + AW'(cur_col);

    dram_addr_ctrl #(.PAGES(PAGES), .COLS(COLS), .PW(PW), .CW(CW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_page (set_page),
        .set_col  (set_col),
        .addr_val (addr_val),
        .step     (wr_go | rd_go),
        .page_q   (cur_page),
        .col_q    (cur_col)
    );

    dram_scan_map #(.PAGES(PAGES), .COLS(COLS), .PW(PW), .CW(CW), .AW(AW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_dir   (set_dir),
        .dir_val   (dir_val),
        .scan_page (scan_page),
        .scan_seg  (scan_seg),
        .seg_rev   (seg_rev),
        .scan_addr (scan_addr),
        .scan_ok   (scan_ok)
    );

    dram_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk        (clk),
        .we         (wr_go),
        .host_addr  (host_addr),
        .wdata      (wbyte),
        .host_rdata (host_rdata),
        .scan_addr  (scan_addr),
        .scan_rdata (scan_raw)
    );

    always_comb begin
        st_d         = st_q;
        st_d.scan_ok = scan_ok;
        if (wr_go)
            st_d.holder = wbyte;
        else if (rd_go)
            st_d.holder = host_rdata & keep_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.holder;
    assign scan_data = st_q.scan_ok ? scan_raw : '0;
endmodule

// File: rtl/dram_host_port_chk.sv
module dram_host_port_chk #(
    parameter int PAGES = dram_pkg::PAGES,
    parameter int COLS  = dram_pkg::COLS,
    parameter int DW    = dram_pkg::DW,
    parameter int PW    = dram_pkg::PW,
    parameter int CW    = dram_pkg::CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          set_page,
    input logic          set_col,
    input logic          set_dir,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] cur_page,
    input logic [CW-1:0] cur_col
);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [PW-1:0] IND_PAGE = PW'(PAGES - 1);

    logic access;
    assign access = (wr_en | rd_en) & ~set_page & ~set_col;

    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_page <= IND_PAGE); // R2

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_col <= LAST_COL); // R4

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> cur_col == (($past(cur_col) == LAST_COL) ? LAST_COL : $past(cur_col) + 8'd1)); // R3

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> $stable(cur_page)); // R4

    AST_WR_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_page && !set_col && cur_page != IND_PAGE) |=> rd_data == $past(wr_data)); // R5

    AST_IND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cur_page == IND_PAGE) |=> rd_data[DW-1:1] == '0); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !set_page && !set_col && !set_dir) |=> ($stable(rd_data) && $stable(cur_col) && $stable(cur_page))); // R6
endmodule

bind dram_host_port dram_host_port_chk #(
    .PAGES(PAGES), .COLS(COLS), .DW(DW), .PW(PW), .CW(CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_page (set_page),
    .set_col  (set_col),
    .set_dir  (set_dir),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .cur_page (cur_page),
    .cur_col  (cur_col)
);

// File: tb/tb_dram_host_port.sv
module tb_dram_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_page = 0, set_col = 0, set_dir = 0, dir_val = 0;
    logic [7:0] addr_val = '0;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] cur_page;
    logic [7:0] cur_col;
    logic       seg_rev;
    logic [3:0] scan_page = '0;
    logic [7:0] scan_seg = '0;
    logic [7:0] scan_data;

    always #4 clk = ~clk;

    dram_host_port dut (.*);

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] ref_mem [9*132];
    int         m_page = 0, m_col = 0, m_dir = 0;
    logic [7:0] m_hold = '0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected byte per accepted read
    always @(negedge clk) begin
        if (rst_n && rd_en && !wr_en && !set_page && !set_col) begin
            if (exp_q.size() == 0) begin
                chk("R6 (no expected item)", rd_data, 32'hFFFF);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // driver: drives one cycle, updates the model per R2..R10
    task automatic op(bit sp, bit sc, bit w, bit r, logic [7:0] v,
                      logic [7:0] wd, string tag);
        @(posedge clk); #1;
        set_page = sp; set_col = sc; wr_en = w; rd_en = r;
        addr_val = v; wr_data = wd; set_dir = 0;
        if (!(sp || sc)) begin
            if (w) begin
                logic [7:0] b;
                b = (m_page == 8) ? (wd & 8'h01) : wd;
                ref_mem[m_page*132 + m_col] = b;
                m_hold = b;
                if (m_col != 131) m_col++;
            end else if (r) begin
                exp_q.push_back(m_hold);
                tag_q.push_back(tag);
                m_hold = ref_mem[m_page*132 + m_col];
                if (m_col != 131) m_col++;
            end
        end
        if (sp && v <= 8)   m_page = v;
        if (sc && v <= 131) m_col = v;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        set_page = 0; set_col = 0; wr_en = 0; rd_en = 0; set_dir = 0;
    endtask

    task automatic set_direction(bit d);
        @(posedge clk); #1;
        set_page = 0; set_col = 0; wr_en = 0; rd_en = 0;
        set_dir = 1; dir_val = d; m_dir = d;
    endtask

    task automatic scan_chk(int p, int s, string tag);
        logic [7:0] e;
        @(posedge clk); #1;
        set_dir = 0; set_page = 0; set_col = 0; wr_en = 0; rd_en = 0;
        scan_page = 4'(p); scan_seg = 8'(s);
        if (p > 8 || s > 131) e = 8'h00;
        else e = ref_mem[p*132 + (m_dir ? 131 - s : s)];
        @(posedge clk);
        @(negedge clk);
        chk(tag, scan_data, e);
    endtask

    task automatic status_chk(string tag);
        @(negedge clk);
        chk({tag, " page"}, cur_page, m_page);
        chk({tag, " col"},  cur_col,  m_col);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 page", cur_page, 0);
        chk("R1 col", cur_col, 0);
        chk("R1 holder", rd_data, 0);
        chk("R1 seg_rev", seg_rev, 0);

        // fill every page, column stepping past the end (R3, R4)
        for (int p = 0; p < 9; p++) begin
            op(1, 0, 0, 0, 8'(p), 0, "");
            op(0, 1, 0, 0, 8'd0, 0, "");
            for (int c = 0; c < 132; c++)
                op(0, 0, 1, 0, 0, 8'((p*37 + c*5 + 1) ^ 8'hC3), "");
            idle();
            if (p == 0) status_chk("R3 R4 after full row");
        end
        op(0, 0, 1, 0, 0, 8'hFE, "");
        idle();
        status_chk("R4 saturate at 131");

        // R2: out-of-range and independence
        op(1, 0, 0, 0, 8'd9, 0, ""); idle();
        status_chk("R2 page 9 ignored");
        op(0, 1, 0, 0, 8'd200, 0, ""); idle();
        status_chk("R2 col 200 ignored");
        op(1, 0, 0, 0, 8'd2, 0, ""); idle();
        status_chk("R2 R8 page set keeps col");
        op(0, 1, 0, 0, 8'd5, 0, ""); idle();
        status_chk("R8 col set visible");

        // R6: dummy read then real data
        for (int i = 0; i < 4; i++) op(0, 0, 0, 1, 0, 0, "R6 read pipeline");
        idle();
        status_chk("R3 col after reads");

        // R5: write then read returns written byte, committed to array
        op(0, 0, 1, 0, 0, 8'hA5, "");
        op(0, 0, 0, 1, 0, 0, "R5 R6 read after write");
        op(0, 0, 0, 1, 0, 0, "R6 next column");
        op(0, 1, 0, 0, 8'd9, 0, "");
        op(0, 0, 0, 1, 0, 0, "R6 dummy after set");
        op(0, 0, 0, 1, 0, 0, "R5 committed byte");
        idle();

        // R7: indicator page keeps only bit 0
        op(1, 0, 0, 0, 8'd8, 0, "");
        op(0, 1, 0, 0, 8'd3, 0, "");
        op(0, 0, 1, 0, 0, 8'hFE, "");
        op(0, 0, 1, 0, 0, 8'hFF, "");
        op(0, 1, 0, 0, 8'd3, 0, "");
        op(0, 0, 0, 1, 0, 0, "R7 dummy");
        op(0, 0, 0, 1, 0, 0, "R7 masked 0xFE");
        op(0, 0, 0, 1, 0, 0, "R7 masked 0xFF");
        idle();

        // R10: address command beats access; write beats read
        op(1, 0, 0, 0, 8'd2, 0, "");
        op(0, 1, 1, 0, 8'd20, 8'h3C, "");
        idle();
        status_chk("R10 col after blocked write");
        op(0, 0, 0, 1, 0, 0, "R10 dummy");
        op(0, 0, 0, 1, 0, 0, "R10 blocked write left byte");
        op(0, 0, 1, 1, 0, 8'h77, "");
        op(0, 1, 0, 0, 8'd22, 0, "");
        op(0, 0, 0, 1, 0, 0, "R10 dummy2");
        op(0, 0, 0, 1, 0, 0, "R10 write won over read");
        idle();
        status_chk("R10 status");

        // R9: scan port both directions
        scan_chk(2, 5, "R9 forward seg 5");
        scan_chk(0, 131, "R9 forward seg 131");
        set_direction(1);
        idle();
        @(negedge clk);
        chk("R9 seg_rev set", seg_rev, 1);
        scan_chk(2, 0, "R9 reverse seg 0");
        scan_chk(8, 128, "R9 reverse indicator");
        scan_chk(9, 4, "R9 page out of range");
        set_direction(0);
        idle();
        scan_chk(3, 140, "R9 seg out of range");

        chk("R6 scoreboard drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule